// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of finished analog-to-digital conversion results and tests each one against a programmed 10-bit threshold. A 12-bit result is presented together with a one-cycle valid strobe. Only the upper ten bits take part in the test, so the two finest bits of the converter never affect the outcome. A select input chooses the test. The result can be required to be at or above the threshold, or strictly below it.

When a qualifying result meets the test, a sticky flag is raised on the next clock edge. The flag stays up until software pulses a clear input. A separate interrupt-enable input decides whether the flag reaches the interrupt line, which lets software poll the flag with the interrupt masked.

Comparison can be switched off as a whole. It can also be narrowed so that only results tagged with one programmed channel number are tested. Switching comparison off never erases a flag that is already raised.

Top module: `adc_window_cmp`

## Requirements
- R1: While rst_n is low the flag and the interrupt output are 0, and both stay 0 on the first cycle after release.
- R2: With cmp_en=1 and cmp_ge_sel=1, a valid result whose bits 11:2 are greater than or equal to cmp_value sets cmp_flag on the next rising edge. Equality counts as a hit.
- R3: With cmp_en=1 and cmp_ge_sel=0, a valid result whose bits 11:2 are strictly less than cmp_value sets cmp_flag on the next rising edge. Equality is not a hit.
- R4: Result bits 1:0 have no effect on the outcome.
- R5: While cmp_en=0 no result sets the flag, and a flag that is already set stays set unless it is cleared.
- R6: A result presented while res_valid=0 never sets the flag.
- R7: The flag is sticky. It holds its value until flag_clr is pulsed, and it reads 0 on the cycle after the pulse.
- R8: When a hit and flag_clr arrive in the same cycle, the hit wins and the flag reads 1 afterwards.
- R9: cmp_irq equals cmp_flag AND irq_en in the same cycle, with no extra delay.
- R10: With chan_single=1 only results whose res_chan equals chan_sel can set the flag. With chan_single=0 every channel can.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a finished result |
| res_data | input | 12 | Conversion result |
| res_chan | input | 5 | Channel number of the result |
| cmp_en | input | 1 | Comparison enable |
| cmp_value | input | 10 | Threshold, compared with result bits 11:2 |
| cmp_ge_sel | input | 1 | 1: hit when at or above; 0: hit when below |
| chan_single | input | 1 | 1: compare only results of channel chan_sel |
| chan_sel | input | 5 | Channel tested in single-channel mode |
| irq_en | input | 1 | Routes the flag to the interrupt line |
| flag_clr | input | 1 | Clears the sticky flag |
| cmp_flag | output | 1 | Sticky comparison flag |
| cmp_irq | output | 1 | Gated interrupt request |

## Verification
The block holds a single bit of state, so any fault in it shows up at cmp_flag on the edge that follows the stimulus. Examples are a lost set, a spurious set, or a clear that is missed or overrides a hit. A wrong compare slice or a wrong condition polarity shows up on the first result that lands at the threshold boundary. A wrong channel qualification shows up on the first result from another channel. A gating fault on the interrupt path shows up in the same cycle irq_en or the flag changes. For these reasons the bench compares both outputs with its reference on every clock, and it drives results exactly at, just below and just above the threshold.

// File: rtl/adcmp_pkg.sv
// Package adcmp_pkg
// Shared widths and the encoding of the condition-select input for the
// ADC result window comparator. Assumes results are right-aligned integers.
package adcmp_pkg;

    localparam int unsigned DEF_RES_W = 12;
    localparam int unsigned DEF_CMP_W = 10;
    localparam int unsigned DEF_CH_W  = 5;

    // Encoding of the condition select input
    typedef enum logic {
        COND_BELOW    = 1'b0,
        COND_AT_ABOVE = 1'b1
    } cmp_cond_e;

endpackage

// File: rtl/adcmp_sample_gate.sv
// Module adcmp_sample_gate
// Decides whether the result on the inputs this cycle takes part in a
// comparison: it must be strobed valid, comparison must be enabled and, when
// channel filtering is built in and selected, its channel must match.
// Assumes res_valid is a single-cycle strobe per result.
module adcmp_sample_gate #(
    parameter int unsigned CH_W        = adcmp_pkg::DEF_CH_W,
    parameter bit          CHAN_FILTER = 1'b1
) (
    input  logic            res_valid,
    input  logic [CH_W-1:0] res_chan,
    input  logic            cmp_en,
    input  logic            chan_single,
    input  logic [CH_W-1:0] chan_sel,
    output logic            sample_ok
);

    logic chan_ok;

    generate
        if (CHAN_FILTER) begin : g_filter
            // Channel qualification: pass all, or only the programmed channel
            always_comb begin
                chan_ok = chan_single ? (res_chan == chan_sel) : 1'b1;
            end
        end else begin : g_no_filter
            logic unused_chan;
            // Filter not built: every channel qualifies
            always_comb begin
                unused_chan = ^{res_chan, chan_sel, chan_single};
                chan_ok     = 1'b1;
            end
        end
    endgenerate

    // Combine strobe, enable and channel qualification
    always_comb begin
        sample_ok = res_valid & cmp_en & chan_ok;
    end

endmodule

// File: rtl/adcmp_level_cmp.sv
// Module adcmp_level_cmp
// Compares the upper CMP_W bits of a RES_W-bit result with the threshold
// under the selected condition. The low RES_W-CMP_W bits are discarded.
// Assumes RES_W > CMP_W.
module adcmp_level_cmp
    import adcmp_pkg::*;
#(
    parameter int unsigned RES_W = DEF_RES_W,
    parameter int unsigned CMP_W = DEF_CMP_W
) (
    input  logic [RES_W-1:0] res_data,
    input  logic [CMP_W-1:0] cmp_value,
    input  logic             cmp_ge_sel,
    output logic             cond_met
);

    localparam int unsigned DROP = RES_W - CMP_W;

    logic [CMP_W-1:0] res_top;
    logic             unused_lsbs;
    logic             at_or_above;
    cmp_cond_e        cond;

    // Split the result into compared and discarded parts
    always_comb begin
        res_top     = res_data[RES_W-1:DROP];
        unused_lsbs = ^res_data[DROP-1:0];
    end

    // Magnitude compare and condition selection
    always_comb begin
        cond        = cmp_cond_e'(cmp_ge_sel);
        at_or_above = (res_top >= cmp_value);
        case (cond)
            COND_AT_ABOVE: cond_met = at_or_above;
            default:       cond_met = ~at_or_above;
        endcase
    end

endmodule

// File: rtl/adcmp_sticky_flag.sv
// Module adcmp_sticky_flag
// Holds the comparison flag: set by a hit, cleared by software, a hit in the
// same cycle as a clear takes priority. Drives the gated interrupt request.
// Assumes synchronous active-low reset.
module adcmp_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);

    // Flag register: reset, set on hit, else clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt gating, no added latency
    always_comb begin
        irq = flag_q & irq_en;
    end

endmodule

// File: rtl/adc_window_cmp.sv
// Module adc_window_cmp
// Top of the ADC result window comparator. Qualifies each incoming result,
// tests its upper bits against the threshold and keeps a sticky flag with a
// gated interrupt. Assumes all control inputs are quasi-static register
// fields sampled on the same clock.
module adc_window_cmp
    import adcmp_pkg::*;
#(
    parameter int unsigned RES_W       = DEF_RES_W,
    parameter int unsigned CMP_W       = DEF_CMP_W,
    parameter int unsigned CH_W        = DEF_CH_W,
    parameter bit          CHAN_FILTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [CH_W-1:0]  res_chan,
    input  logic             cmp_en,
    input  logic [CMP_W-1:0] cmp_value,
    input  logic             cmp_ge_sel,
    input  logic             chan_single,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             cmp_flag,
    output logic             cmp_irq
);

    logic sample_ok;
    logic cond_met;
    logic hit;

    adcmp_sample_gate #(
        .CH_W        (CH_W),
        .CHAN_FILTER (CHAN_FILTER)
    ) u_gate (
        .res_valid   (res_valid),
        .res_chan    (res_chan),
        .cmp_en      (cmp_en),
        .chan_single (chan_single),
        .chan_sel    (chan_sel),
        .sample_ok   (sample_ok)
    );

    adcmp_level_cmp #(
        .RES_W (RES_W),
        .CMP_W (CMP_W)
    ) u_cmp (
        .res_data   (res_data),
        .cmp_value  (cmp_value),
        .cmp_ge_sel (cmp_ge_sel),
        .cond_met   (cond_met)
    );

    // A hit needs a qualified sample that meets the condition
    always_comb begin
        hit = sample_ok & cond_met;
    end

    adcmp_sticky_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .flag_q   (cmp_flag),
        .irq      (cmp_irq)
    );

endmodule

// File: rtl/adc_window_cmp_chk.sv
// Module adc_window_cmp_chk
// Assertion checker bound to adc_window_cmp; observes ports only.
module adc_window_cmp_chk #(
    parameter int unsigned RES_W = 12,
    parameter int unsigned CMP_W = 10,
    parameter int unsigned CH_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data,
    input logic [CH_W-1:0]  res_chan,
    input logic             cmp_en,
    input logic [CMP_W-1:0] cmp_value,
    input logic             cmp_ge_sel,
    input logic             chan_single,
    input logic [CH_W-1:0]  chan_sel,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             cmp_flag,
    input logic             cmp_irq
);

    logic [CMP_W-1:0] top_bits;
    logic             qual;
    logic             cond;
    logic             hit_now;

    // Independent view of a hit, from the ports
    always_comb begin
        top_bits = res_data[RES_W-1:RES_W-CMP_W];
        qual     = res_valid && cmp_en && (!chan_single || res_chan == chan_sel);
        cond     = cmp_ge_sel ? !(top_bits < cmp_value) : (top_bits < cmp_value);
        hit_now  = qual && cond;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!cmp_flag && !cmp_irq));

    p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_now |=> cmp_flag);

    p_disabled_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !flag_clr) |=> $stable(cmp_flag));

    p_no_valid_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !cmp_flag) |=> !cmp_flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit_now) |=> !cmp_flag);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !cmp_irq);

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> cmp_flag);

    p_other_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_single && res_chan != chan_sel && !cmp_flag) |=> !cmp_flag);

endmodule

bind adc_window_cmp adc_window_cmp_chk #(
    .RES_W (RES_W),
    .CMP_W (CMP_W),
    .CH_W  (CH_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_chan    (res_chan),
    .cmp_en      (cmp_en),
    .cmp_value   (cmp_value),
    .cmp_ge_sel  (cmp_ge_sel),
    .chan_single (chan_single),
    .chan_sel    (chan_sel),
    .irq_en      (irq_en),
    .flag_clr    (flag_clr),
    .cmp_flag    (cmp_flag),
    .cmp_irq     (cmp_irq)
);

// File: tb/adc_window_cmp_tb_top.sv
// Bench for adc_window_cmp: directed checks plus a behavioural reference
// model compared on every clock.
module adc_window_cmp_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic        cmp_en = 1'b0;
    logic [9:0]  cmp_value = '0;
    logic        cmp_ge_sel = 1'b0;
    logic        chan_single = 1'b0;
    logic [4:0]  chan_sel = '0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        cmp_flag;
    logic        cmp_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_window_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .cmp_en(cmp_en), .cmp_value(cmp_value),
        .cmp_ge_sel(cmp_ge_sel), .chan_single(chan_single), .chan_sel(chan_sel),
        .irq_en(irq_en), .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    // Reference model: integer arithmetic on the requirements
    always @(posedge clk) begin
        int upper;
        bit hit;
        upper = int'(res_data) / 4;
        hit = res_valid && cmp_en && (!chan_single || res_chan == chan_sel) &&
              (cmp_ge_sel ? (upper >= int'(cmp_value)) : (upper < int'(cmp_value)));
        if (!rst_n)        m_flag <= 0;
        else if (hit)      m_flag <= 1;
        else if (flag_clr) m_flag <= 0;
    end

    // Per-cycle comparison a quarter period after the edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (!done) begin
            int m_irq;
            m_irq = m_flag & int'(irq_en);
            n_run++;
            if (int'(cmp_flag) != m_flag || int'(cmp_irq) != m_irq) begin
                n_fail++;
                $display("FAIL model R2/R9: flag=%0b irq=%0b expected flag=%0d irq=%0d",
                         cmp_flag, cmp_irq, m_flag, m_irq);
            end
        end
    end

    task automatic chk(input bit act, input bit exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then wait until the
    // outputs after the next rising edge are settled
    task automatic step(input bit v, input int data, input int ch, input bit clr);
        @(negedge clk);
        res_valid = v;
        res_data  = 12'(data);
        res_chan  = 5'(ch);
        flag_clr  = clr;
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic clear_flag();
        step(1'b0, 0, 0, 1'b1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk(cmp_flag, 1'b0, "R1 flag in reset");
        chk(cmp_irq, 1'b0, "R1 irq in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_P/4);
        chk(cmp_flag, 1'b0, "R1 flag after release");

        cmp_en = 1'b1; cmp_ge_sel = 1'b1; cmp_value = 10'd100;
        step(1'b1, 100*4, 0, 1'b0);
        chk(cmp_flag, 1'b1, "R2 equal sets (ge)");
        chk(cmp_irq, 1'b1, "R9 irq follows flag");
        step(1'b0, 0, 0, 1'b0);
        chk(cmp_flag, 1'b1, "R7 flag sticky");
        clear_flag();
        chk(cmp_flag, 1'b0, "R7 clear");
        step(1'b1, 99*4 + 3, 0, 1'b0);
        chk(cmp_flag, 1'b0, "R2/R4 below with lsbs set, no hit");
        step(1'b1, 100*4 + 3, 0, 1'b0);
        chk(cmp_flag, 1'b1, "R4 lsbs ignored, hit");
        clear_flag();

        cmp_ge_sel = 1'b0; cmp_value = 10'd50;
        step(1'b1, 50*4, 0, 1'b0);
        chk(cmp_flag, 1'b0, "R3 equal is no hit (below)");
        step(1'b1, 49*4 + 3, 0, 1'b0);
        chk(cmp_flag, 1'b1, "R3 below sets");
        clear_flag();
        cmp_value = 10'd101;
        step(1'b1, 100*4 + 3, 0, 1'b0);
        chk(cmp_flag, 1'b1, "R4 lsbs ignored (below)");
        clear_flag();

        cmp_en = 1'b0;
        step(1'b1, 0, 0, 1'b0);
        chk(cmp_flag, 1'b0, "R5 disabled no set");
        cmp_en = 1'b1;
        step(1'b1, 0, 0, 1'b0);
        cmp_en = 1'b0;
        step(1'b1, 4000, 0, 1'b0);
        chk(cmp_flag, 1'b1, "R5 disabled keeps flag");
        cmp_en = 1'b1;
        clear_flag();

        step(1'b0, 0, 0, 1'b0);
        chk(cmp_flag, 1'b0, "R6 no valid no set");

        step(1'b1, 0, 0, 1'b0);
        step(1'b1, 0, 0, 1'b1);
        chk(cmp_flag, 1'b1, "R8 hit beats clear");
        step(1'b0, 0, 0, 1'b0);
        @(negedge clk);
        irq_en = 1'b0;
        #(CLK_P/4);
        chk(cmp_irq, 1'b0, "R9 irq masked");
        irq_en = 1'b1;
        #1;
        chk(cmp_irq, 1'b1, "R9 irq unmasked same cycle");
        clear_flag();

        chan_single = 1'b1; chan_sel = 5'd3;
        step(1'b1, 0, 4, 1'b0);
        chk(cmp_flag, 1'b0, "R10 other channel ignored");
        step(1'b1, 0, 3, 1'b0);
        chk(cmp_flag, 1'b1, "R10 selected channel hits");
        clear_flag();
        chan_single = 1'b0;
        step(1'b1, 0, 7, 1'b0);
        chk(cmp_flag, 1'b1, "R10 all-channel mode hits");
        clear_flag();

        for (int i = 0; i < 2000; i++) begin
            if (i % 50 == 0) begin
                @(negedge clk);
                cmp_en      = ($urandom_range(0, 3) != 0);
                cmp_ge_sel  = 1'($urandom_range(0, 1));
                cmp_value   = 10'($urandom_range(0, 1023));
                chan_single = 1'($urandom_range(0, 1));
                chan_sel    = 5'($urandom_range(0, 3));
                irq_en      = 1'($urandom_range(0, 1));
            end
            step(1'($urandom_range(0, 1)),
                 (int'(cmp_value) * 4 + int'($urandom_range(0, 7)) - 2) & 12'hfff,
                 int'($urandom_range(0, 3)),
                 ($urandom_range(0, 5) == 0));
        end
        step(1'b0, 0, 0, 1'b0);
        finish_run();
    end

endmodule